// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two timeout stages. Software sets two 20-bit preload values through a small byte-addressed register file. When the timer is enabled or kicked, the first preload is zero-extended into a 35-bit down counter. The counter then steps down once for each tick while the timer runs. Counting is zero-based, so a preload of N gives a stage that lasts N+1 ticks. Software therefore programs the wanted period minus one.

When the first stage runs out, the block raises a sticky interrupt. It then loads the second preload and counts again. If the second stage also runs out, the block drives a one-clock timeout reset and starts over in stage 1 with the first preload. A kick pulse restarts stage 1 at any time. Dropping the enable input freezes the counter and the stage.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, both preloads hold 0xFFFFF. Bytes 0, 1, 2, 4, 5 and 6 read back 0xFF, 0xFF, 0x0F, 0xFF, 0xFF and 0x0F. The irq and timeout outputs are 0, the stage output is 0 (stage 1) and the count is 0.
- R2: Byte offsets 0, 1 and 2 hold bits 7:0, 15:8 and 19:16 of the stage-1 preload. Offsets 4, 5 and 6 hold the same bits of the stage-2 preload. A write takes effect at the clock edge and reads are combinational. Offsets 3 and 7 read 0x00, and writes to them change nothing.
- R3: Bits 7:4 of offsets 2 and 6 always read 0, and writes to those bits are dropped.
- R4: When enable rises, the counter loads the stage-1 preload zero-extended to 35 bits, and the stage becomes 1.
- R5: While the timer runs, each tick with a nonzero count lowers the count by exactly one. A cycle without a tick leaves the count unchanged.
- R6: In stage 1, a tick that finds the count at 0 ends the stage, so the stage lasts preload+1 ticks. On that tick the irq output is set, the stage output goes to 1 (stage 2) and the count takes the stage-2 preload.
- R7: irq stays at 1 until a cycle with irq_clr high clears it. If irq_clr is high in the same cycle that stage 1 expires, irq stays at 1.
- R8: In stage 2, a tick that finds the count at 0 drives timeout_rst high for exactly one clock. In that same cycle the stage returns to 1 and the count reloads the stage-1 preload.
- R9: A kick, whatever the level of enable, loads the stage-1 preload and selects stage 1. When a kick and an expiring tick fall in the same cycle, the kick wins: no irq is set and no timeout is issued.
- R10: While enable is low, ticks are ignored, and the count and the stage hold their values (a kick still acts as in R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; a rising level restarts stage 1 |
| tick | input | 1 | Count tick |
| kick | input | 1 | Restart stage 1 with a fresh load |
| irq_clr | input | 1 | Clears the sticky stage-1 interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| count | output | 35 | Current down-counter value |
| in_stage2 | output | 1 | 1 while in the second stage |
| irq | output | 1 | Sticky stage-1 expiry interrupt |
| timeout_rst | output | 1 | One-clock pulse on stage-2 expiry |

## Verification
The most delicate overlap is a kick arriving in the very cycle a tick would end a stage. The bench first lets the counter run down to zero, once in stage 1 and once in stage 2. It then drives kick and tick in the same cycle and expects the stage-1 reload with no interrupt and no timeout pulse. A second overlap puts irq_clr in the same cycle as a stage-1 expiry. Here the bench expects the interrupt to remain set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_W = 20;
  localparam int CNT_W = 35;

  typedef enum logic {STG_ONE = 1'b0, STG_TWO = 1'b1} stage_e;

  // zero-extend a preload into the counter width
  function automatic logic [CNT_W-1:0] widen(input logic [PRE_W-1:0] pre);
    return {{(CNT_W-PRE_W){1'b0}}, pre};
  endfunction

  // one decrement step of the zero-based counter
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/wdt_preload_regs.sv
module wdt_preload_regs
  import wdt_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [PW-1:0] pre1,
  output logic [PW-1:0] pre2
);
  localparam int TOP_W = PW - 16;

  logic [1:0][PW-1:0] pre_q;
  logic [1:0]         bsel;
  logic               which;

  assign bsel  = reg_addr[1:0];
  assign which = reg_addr[2];

  for (genvar g = 0; g < 2; g++) begin : g_pre
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q[g] <= '1;
      end else if (reg_wr && (which == g[0])) begin
        case (bsel)
          2'd0: pre_q[g][7:0]   <= reg_wdata;
          2'd1: pre_q[g][15:8]  <= reg_wdata;
          2'd2: pre_q[g][PW-1:16] <= reg_wdata[TOP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (bsel)
      2'd0: reg_rdata = pre_q[which][7:0];
      2'd1: reg_rdata = pre_q[which][15:8];
      2'd2: reg_rdata[TOP_W-1:0] = pre_q[which][PW-1:16];
      default: reg_rdata = '0;
    endcase
  end

  assign pre1 = pre_q[0];
  assign pre2 = pre_q[1];

  // R3: top byte keeps only the write data nibble
  assert_top_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && bsel == 2'd2) |=> (pre_q[$past(which)][PW-1:16] == $past(reg_wdata[TOP_W-1:0])));

  // R2: unmapped offsets never alter the preloads
  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && bsel == 2'd3) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_stage_core.sv
module wdt_stage_core
  import wdt_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          kick,
  input  logic          irq_clr,
  input  logic [PW-1:0] pre1,
  input  logic [PW-1:0] pre2,
  output logic [CW-1:0] count,
  output logic          in_stage2,
  output logic          irq,
  output logic          timeout_rst
);
  stage_e        stage_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, irq_q, tmo_q;

  // named internal events
  logic start_ev, load_ev, run_tick, at_zero, expire_ev, irq_set, tmo_set;

  assign start_ev  = enable && !en_q;
  assign load_ev   = kick || start_ev;
  assign run_tick  = enable && tick && !load_ev;
  assign at_zero   = (cnt_q == '0);
  assign expire_ev = run_tick && at_zero;
  assign irq_set   = expire_ev && (stage_q == STG_ONE);
  assign tmo_set   = expire_ev && (stage_q == STG_TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_ONE;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      en_q  <= enable;
      tmo_q <= tmo_set;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (load_ev) begin
        stage_q <= STG_ONE;
        cnt_q   <= widen(pre1);
      end else if (irq_set) begin
        stage_q <= STG_TWO;
        cnt_q   <= widen(pre2);
      end else if (tmo_set) begin
        stage_q <= STG_ONE;
        cnt_q   <= widen(pre1);
      end else if (run_tick) begin
        cnt_q   <= step_down(cnt_q);
      end
    end
  end

  assign count       = cnt_q;
  assign in_stage2   = (stage_q == STG_TWO);
  assign irq         = irq_q;
  assign timeout_rst = tmo_q;

  // R8: timeout lasts one clock and lands in stage 1
  assert_tmo_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_rst |=> !timeout_rst);
  assert_tmo_stage1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_rst |-> !in_stage2);
  // R9: a kick always yields stage 1 with the stage-1 preload
  assert_kick_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!in_stage2 && count == widen($past(pre1)) && !timeout_rst));
  // R10: disabled and not kicked means frozen
  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !kick) |=> ($stable(count) && $stable(in_stage2)));
  // R5: running tick on nonzero count decrements by one
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && tick && !kick && count != '0) |=> (count == $past(count) - 1));
  // R6: stage-1 expiry moves to stage 2 and raises irq
  assert_stage1_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && tick && !kick && count == '0 && !in_stage2) |=> (in_stage2 && irq));
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             kick,
  input  logic             irq_clr,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [CNT_W-1:0] count,
  output logic             in_stage2,
  output logic             irq,
  output logic             timeout_rst
);
  logic [PRE_W-1:0] pre1, pre2;

  wdt_preload_regs #(.PW(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pre1(pre1), .pre2(pre2)
  );

  wdt_stage_core #(.PW(PRE_W), .CW(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .kick(kick),
    .irq_clr(irq_clr), .pre1(pre1), .pre2(pre2), .count(count),
    .in_stage2(in_stage2), .irq(irq), .timeout_rst(timeout_rst)
  );
endmodule

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enable = 0, tick = 0, kick = 0, irq_clr = 0, reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [34:0] count;
  logic        in_stage2, irq, timeout_rst;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_stage i_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .kick(kick),
    .irq_clr(irq_clr), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .in_stage2(in_stage2), .irq(irq),
    .timeout_rst(timeout_rst)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic k, input logic e, input logic c);
    @(negedge clk);
    tick = t; kick = k; enable = e; irq_clr = c;
    @(posedge clk); #1;
    tick = 0; kick = 0; irq_clr = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic state(input string req, input logic [34:0] c, input logic s2,
                       input logic ir, input logic to);
    check({req, " count"}, count, c);
    check({req, " stage"}, in_stage2, s2);
    check({req, " irq"}, irq, ir);
    check({req, " timeout"}, timeout_rst, to);
  endtask

  task automatic t_reset;
    state("R1 reset", 0, 0, 0, 0);
    rd("R1 b0", 0, 8'hFF); rd("R1 b1", 1, 8'hFF); rd("R1 b2", 2, 8'h0F);
    rd("R1 b4", 4, 8'hFF); rd("R1 b5", 5, 8'hFF); rd("R1 b6", 6, 8'h0F);
  endtask

  task automatic t_regs;  // pre1 = 3, pre2 = 2
    wr(0, 8'h03); wr(1, 8'h00); wr(2, 8'hF0);
    wr(4, 8'h02); wr(5, 8'h00); wr(6, 8'h00);
    wr(3, 8'hAA); wr(7, 8'h55);
    rd("R2 b0", 0, 8'h03); rd("R3 b2 nibble", 2, 8'h00);
    rd("R2 b4", 4, 8'h02); rd("R2 off3", 3, 8'h00); rd("R2 off7", 7, 8'h00);
    wr(6, 8'hA5); rd("R3 b6 nibble", 6, 8'h05); wr(6, 8'h00);
  endtask

  task automatic t_start_and_count;
    cyc(0, 0, 1, 0); state("R4 start", 3, 0, 0, 0);
    cyc(0, 0, 1, 0); state("R5 no tick", 3, 0, 0, 0);
    cyc(1, 0, 1, 0); state("R5 dec", 2, 0, 0, 0);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); state("R5 zero", 0, 0, 0, 0);
    cyc(1, 0, 1, 1); state("R6 R7 expire beats clr", 2, 1, 1, 0);
    cyc(1, 0, 1, 0); state("R7 sticky", 1, 1, 1, 0);
    cyc(0, 0, 1, 1); state("R7 clr", 1, 1, 0, 0);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); state("R8 pulse", 3, 0, 0, 1);
    cyc(0, 0, 1, 0); state("R8 single", 3, 0, 0, 0);
  endtask

  task automatic t_disable;
    cyc(1, 0, 1, 0); state("R5 dec again", 2, 0, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    state("R10 hold", 2, 0, 0, 0);
    cyc(1, 1, 0, 0); state("R9 kick disabled", 3, 0, 0, 0);
    cyc(1, 0, 0, 0); state("R10 hold after kick", 3, 0, 0, 0);
    cyc(1, 0, 1, 0); state("R4 restart no dec", 3, 0, 0, 0);
  endtask

  task automatic t_kick_races;
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0);
    state("R6 at stage2 zero", 0, 1, 1, 0);
    cyc(1, 1, 1, 1); state("R9 kick vs stage2 expiry", 3, 0, 0, 0);
    cyc(0, 0, 1, 0); check("R9 no timeout later", timeout_rst, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0);
    cyc(1, 1, 1, 0); state("R9 kick vs stage1 expiry", 3, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0);
    state("R9 kick in stage2 setup", 1, 1, 1, 0);
    cyc(0, 1, 1, 1); state("R9 kick in stage2", 3, 0, 0, 0);
  endtask

  task automatic t_wide;
    wr(0, 8'hDE); wr(1, 8'hBC); wr(2, 8'h0A);
    cyc(0, 1, 1, 0); check("R4 zero-extend", count, 35'h00ABCDE);
    cyc(1, 0, 1, 0); check("R5 wide dec", count, 35'h00ABCDD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_start_and_count();
    t_disable();
    t_kick_races();
    t_wide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule